// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves 18-bit words between an A bus and a B bus in either direction. Each direction has its own storage stage, and that stage works in one of two ways. In the first, it is a transparent latch: the far bus follows the near bus within the same cycle. In the second, it is a register: it takes a new word on a high-to-low step of that direction's strobe and holds it at all other times. The B-side drive enable is active high and the A-side drive enable is active low. Each tri-state pin is split into an input vector, an output vector and one enable bit, so the block can sit inside a chip.

The block runs on one system clock. The direction strobes are sampled as ordinary inputs. A falling strobe is seen when the strobe was high at one clock edge and low at the next. While a direction is transparent, its storage also loads the near bus on every edge. When transparency ends, the output therefore keeps the word that was present at the last edge before it ended. The two directions share only the clock and the reset.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While a direction's latch enable is 1, its output vector equals the opposite bus input in the same cycle, with no clock edge needed.
- R2: When a latch enable goes from 1 to 0, the output shows the opposite bus input that was sampled at the last clock edge while the enable was still 1.
- R3: While the latch enable is 0 and the strobe shows no 1-to-0 step between edges, the output stays unchanged whatever the bus input does.
- R4: With the latch enable at 0, a strobe sampled as 1 at one clock edge and as 0 at the next stores the bus input sampled at that second edge. The output shows it after that edge.
- R5: A 0-to-1 step of the strobe stores nothing.
- R6: If the strobe is already 0 when the latch enable falls, nothing is stored until a later 1-to-0 strobe step.
- R7: The B-side enable `bOe` is 1 exactly when `abDrvEn` is 1 (active high).
- R8: The A-side enable `aOe` is 1 exactly when `baDrvEnN` is 0 (active low).
- R9: The output vectors carry the transparent or stored word whether or not their enable is asserted.
- R10: The asynchronous active-low reset `rst_n` clears both stored words and both strobe histories to 0. While it is asserted and the latch enables are 0, both outputs read 0.
- R11: The two directions are independent. Both may load, capture or hold in the same cycle without affecting each other.
- R12: If the latch enable falls and the strobe steps 1-to-0 at the same clock edge, the word sampled at that edge is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and storage are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| aIn | input | 18 | Value seen on the A bus |
| aOut | output | 18 | Value driven toward the A bus (B-to-A path) |
| aOe | output | 1 | A bus drive enable |
| bIn | input | 18 | Value seen on the B bus |
| bOut | output | 18 | Value driven toward the B bus (A-to-B path) |
| bOe | output | 1 | B bus drive enable |
| abLatchEn | input | 1 | A-to-B transparent enable |
| abStrobe | input | 1 | A-to-B capture strobe (falling step) |
| abDrvEn | input | 1 | A-to-B drive enable, active high |
| baLatchEn | input | 1 | B-to-A transparent enable |
| baStrobe | input | 1 | B-to-A capture strobe (falling step) |
| baDrvEnN | input | 1 | B-to-A drive enable, active low |

## Verification
Two events can fall on the same edge in one direction: the end of transparency and a 1-to-0 strobe step. The bench makes both happen at one sampled edge and expects the word present at that edge to be kept. The bench also drives both directions through capture and hold in the same cycles, using different data, to show that neither path leaks into the other. After every edge and every input change, the outputs are compared with a behavioural model that keeps one stored word and one strobe history per direction.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int DIRS = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // Strobes from a direction's control to its datapath.
  typedef struct packed {
    logic pass;  // output follows the input combinationally
    logic load;  // storage takes the input at this edge
  } pathStrobe_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        latchEn,
  input  logic        strobe,
  output pathStrobe_t ctl
);

  logic strobePrev;
  logic strobeFall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobePrev <= 1'b0;
    else        strobePrev <= strobe;
  end

  // Falling step: high at the previous edge, low at this one.
  assign strobeFall = strobePrev & ~strobe;

  always_comb begin
    ctl.pass = latchEn;
    ctl.load = latchEn | strobeFall;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pathStrobe_t      ctl,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store <= '0;
    else if (ctl.load) store <= dIn;
  end

  assign dOut = ctl.pass ? dIn : store;

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  input  logic             abLatchEn,
  input  logic             abStrobe,
  input  logic             abDrvEn,
  input  logic             baLatchEn,
  input  logic             baStrobe,
  input  logic             baDrvEnN
);

  logic [WIDTH-1:0] srcBus [DIRS];
  logic [WIDTH-1:0] dstBus [DIRS];
  logic             dirLe  [DIRS];
  logic             dirStb [DIRS];

  assign srcBus[DIR_AB] = aIn;
  assign srcBus[DIR_BA] = bIn;
  assign dirLe[DIR_AB]  = abLatchEn;
  assign dirLe[DIR_BA]  = baLatchEn;
  assign dirStb[DIR_AB] = abStrobe;
  assign dirStb[DIR_BA] = baStrobe;

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    pathStrobe_t ctl;

    xcvr_ctrl uCtrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .latchEn(dirLe[d]),
      .strobe (dirStb[d]),
      .ctl    (ctl)
    );

    xcvr_path #(.WIDTH(WIDTH)) uPath (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ctl),
      .dIn  (srcBus[d]),
      .dOut (dstBus[d])
    );
  end

  assign bOut = dstBus[DIR_AB];
  assign aOut = dstBus[DIR_BA];

  // Opposite enable polarities on the two sides.
  assign bOe = abDrvEn;
  assign aOe = ~baDrvEnN;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic             abLatchEn,
  input logic             abStrobe,
  input logic             baLatchEn,
  input logic             baStrobe
);

  logic [1:0] edgesSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               edgesSeen <= 2'd0;
    else if (edgesSeen != 2'd2) edgesSeen <= edgesSeen + 2'd1;
  end

  // R1: transparent path
  a_r1_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
    abLatchEn |-> bOut == aIn);
  a_r1_pass_ba: assert property (@(posedge clk) disable iff (!rst_n)
    baLatchEn |-> aOut == bIn);

  // R2: leaving transparency keeps the last sampled word
  a_r2_close_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen != 2'd0 && !abLatchEn && $past(abLatchEn)) |-> bOut == $past(aIn));
  a_r2_close_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen != 2'd0 && !baLatchEn && $past(baLatchEn)) |-> aOut == $past(bIn));

  // R3: hold without a falling strobe step
  a_r3_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen == 2'd2 && !abLatchEn && !$past(abLatchEn)
     && !($past(abStrobe, 2) && !$past(abStrobe))) |-> $stable(bOut));
  a_r3_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen == 2'd2 && !baLatchEn && !$past(baLatchEn)
     && !($past(baStrobe, 2) && !$past(baStrobe))) |-> $stable(aOut));

  // R4: falling strobe step captures
  a_r4_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen == 2'd2 && !abLatchEn && $past(abStrobe, 2) && !$past(abStrobe))
      |-> bOut == $past(aIn));
  a_r4_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (edgesSeen == 2'd2 && !baLatchEn && $past(baStrobe, 2) && !$past(baStrobe))
      |-> aOut == $past(bIn));

endmodule

bind bidir_latch_xcvr xcvr_checker #(.WIDTH(WIDTH)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .aIn      (aIn),
  .aOut     (aOut),
  .bIn      (bIn),
  .bOut     (bOut),
  .abLatchEn(abLatchEn),
  .abStrobe (abStrobe),
  .baLatchEn(baLatchEn),
  .baStrobe (baStrobe)
);

// File: tb/sim_bidir_latch_xcvr.sv
module sim_bidir_latch_xcvr;

  localparam int WIDTH = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] aIn = '0, bIn = '0;
  logic [WIDTH-1:0] aOut, bOut;
  logic             aOe, bOe;
  logic             abLatchEn = 1'b0, abStrobe = 1'b1, abDrvEn = 1'b0;
  logic             baLatchEn = 1'b0, baStrobe = 1'b1, baDrvEnN = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bidir_latch_xcvr #(.WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abLatchEn(abLatchEn), .abStrobe(abStrobe), .abDrvEn(abDrvEn),
    .baLatchEn(baLatchEn), .baStrobe(baStrobe), .baDrvEnN(baDrvEnN)
  );

  // Behavioural reference: one stored word and one strobe history per direction.
  logic [WIDTH-1:0] mStoreAb, mStoreBa;
  logic             mPrevAb, mPrevBa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mStoreAb <= '0; mStoreBa <= '0; mPrevAb <= 1'b0; mPrevBa <= 1'b0;
    end else begin
      if (abLatchEn || (mPrevAb && !abStrobe)) mStoreAb <= aIn;
      if (baLatchEn || (mPrevBa && !baStrobe)) mStoreBa <= bIn;
      mPrevAb <= abStrobe;
      mPrevBa <= baStrobe;
    end
  end

  task automatic checkVal(input string tag, input logic [WIDTH-1:0] act,
                          input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    checkVal({tag, " bOut"}, bOut, abLatchEn ? aIn : mStoreAb);
    checkVal({tag, " aOut"}, aOut, baLatchEn ? bIn : mStoreBa);
    checkVal({tag, " R7 bOe"}, {17'd0, bOe}, {17'd0, abDrvEn});
    checkVal({tag, " R8 aOe"}, {17'd0, aOe}, {17'd0, !baDrvEnN});
  endtask

  // Inputs are applied mid-cycle; outputs checked after the change and after the next edge.
  task automatic cyc(input string tag);
    #1 checkAll({tag, " comb"});
    @(posedge clk);
    #1 checkAll({tag, " edge"});
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    #3;
    checkVal("R10 reset bOut", bOut, '0);
    checkVal("R10 reset aOut", aOut, '0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc("R10 after release");

    // R1 / R9: transparent with outputs disabled
    abLatchEn = 1; aIn = 18'h2A5C3; cyc("R1 R9 ab pass");
    aIn = 18'h15A3C; #1 checkVal("R1 ab follows", bOut, 18'h15A3C);
    cyc("R1 ab second");

    // R2: leave transparency, then change input
    abLatchEn = 0; aIn = 18'h3FFFF; cyc("R2 ab close");
    checkVal("R2 ab kept", bOut, 18'h15A3C);

    // R3: hold with strobe steady high, then steady low after one capture
    aIn = 18'h00001; cyc("R3 ab hold high");
    aIn = 18'h00002; cyc("R3 ab hold high 2");
    checkVal("R3 ab still", bOut, 18'h15A3C);

    // R4: falling strobe step captures
    aIn = 18'h1234A; abStrobe = 0; cyc("R4 ab fall");
    checkVal("R4 ab captured", bOut, 18'h1234A);
    aIn = 18'h0BEEF; cyc("R3 ab hold low");

    // R5: rising strobe step does nothing
    abStrobe = 1; aIn = 18'h22222; cyc("R5 ab rise");
    checkVal("R5 ab no capture", bOut, 18'h1234A);

    // R6: strobe already low when latch enable falls
    abStrobe = 0; cyc("R6 prep fall");
    abLatchEn = 1; aIn = 18'h0C0DE; cyc("R6 pass");
    abLatchEn = 0; aIn = 18'h11111; cyc("R6 close low strobe");
    aIn = 18'h33333; cyc("R6 hold");
    checkVal("R6 ab kept", bOut, 18'h0C0DE);
    abStrobe = 1; cyc("R6 rise");
    abStrobe = 0; aIn = 18'h05555; cyc("R6 next fall");
    checkVal("R6 ab captured later", bOut, 18'h05555);

    // R12: latch enable and strobe fall together
    abStrobe = 1; abLatchEn = 1; aIn = 18'h1AAAA; cyc("R12 prep");
    abLatchEn = 0; abStrobe = 0; aIn = 18'h2BBBB; cyc("R12 same edge");
    checkVal("R12 ab stored", bOut, 18'h2BBBB);

    // R7 / R8: enable polarities
    abDrvEn = 1; baDrvEnN = 0; cyc("R7 R8 enabled");
    abDrvEn = 0; baDrvEnN = 1; cyc("R7 R8 disabled");

    // R11: both directions at once with different data
    abStrobe = 1; baStrobe = 1; cyc("R11 prep");
    aIn = 18'h01234; bIn = 18'h3CAFE; abStrobe = 0; baStrobe = 0; cyc("R11 dual capture");
    checkVal("R11 bOut", bOut, 18'h01234);
    checkVal("R11 aOut", aOut, 18'h3CAFE);
    baLatchEn = 1; bIn = 18'h2F00D; aIn = 18'h00777; cyc("R11 ba pass ab hold");
    checkVal("R11 ab unaffected", bOut, 18'h01234);
    baLatchEn = 0; bIn = 18'h10101; cyc("R2 ba close");
    checkVal("R2 ba kept", aOut, 18'h2F00D);
    baStrobe = 1; abStrobe = 1; cyc("R5 dual rise");
    baStrobe = 0; bIn = 18'h3ABCD; cyc("R4 ba fall");
    checkVal("R4 ba captured", aOut, 18'h3ABCD);

    // R10: asynchronous reset mid-cycle
    #2 rst_n = 0; #1;
    checkVal("R10 async bOut", bOut, '0);
    checkVal("R10 async aOut", aOut, '0);
    @(negedge clk); rst_n = 1; cyc("R10 released");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule